// File: doc/BRIEF.md
# Grouped vectored interrupt controller

This block gathers 192 interrupt request lines into 24 banks of 8 and presents a single request line to a processor. Each line can be configured as level-sensitive or edge-sensitive, and as active-high or active-low. Raw inputs first pass through a synchroniser. The qualified requests are captured into per-line pending bits, masked by per-line enable bits, and reduced to one request output.

Software reaches the block over a simple byte-wide register bus. A read of the vector register returns the number of the highest-numbered enabled pending line plus 0x10. The bare value 0x10 means that nothing is pending. Pending bits of edge-sensitive lines are retired by writing ones to them.

Each bank holds four byte registers at consecutive addresses: pending, enable, sense and invert. Bank g starts at 4*g for banks 0 to 3 and at 4*g+4 from bank 4 onwards. Address 0x10 to 0x13 is an unused hole. The vector register sits at 0x70.

Top module: `vec_intc`

## Requirements
- R1: After reset every enable, sense and invert bit is 0, no line is pending, the vector register reads 0x10 and `irq_o` is low.
- R2: The registers of bank g start at 4*g for g<4 and at 4*g+4 for g>=4, in this order: pending (+0), enable (+1), sense (+2), invert (+3). Line n lives in bank n/8 at bit n%8. Enable, sense and invert read back what was written. The hole at 0x10 to 0x13 reads 0, and a write to it changes no register.
- R3: A level line (sense 0) with invert 0 shows its pending bit set while the synchronised input is high, and clear once it is low.
- R4: A level line with invert 1 treats a low input as active.
- R5: An edge line (sense 1) with invert 0 sets its pending bit on a rising input and holds it after the input falls. Writing 1 to the bit clears it. Writing 0 leaves it set.
- R6: An edge line with invert 1 sets its pending bit on a falling input only. A rising input leaves it clear.
- R7: On a level line whose input is still active, a clear write does not leave the pending bit cleared.
- R8: The vector register (address 0x70) reads 0x10 plus the highest line number whose pending and enable bits are both set. The highest bank wins, and within a bank the most significant bit wins. Two consecutive reads return the same value.
- R9: `irq_o` is high exactly when some line is both pending and enabled. A pending but masked line still shows in its pending register.
- R10: When no enabled line is pending, the vector reads 0x10 and `irq_o` is low. An enabled pending line 0 also yields 0x10, but with `irq_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 192 | Raw interrupt request lines, bit n is line n |
| bus_addr | input | 7 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, data valid on `bus_rdata` after the next edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Request to the processor |

## Verification
The assertions on pending bits assume that a raw input holds each level for at least three clock cycles, so that the synchroniser and the history flop see every transition. They also assume that sense and invert are changed only while the affected input is quiet. The bench keeps every line steady for six or more cycles between changes. It configures sense before invert, and it retires any pending bit left by a reconfiguration before it checks. Bus strobes are driven on the falling edge and never overlap a read with a write.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int BANKS       = 24;
    localparam int LINES       = 8;
    localparam int ADDR_W      = 7;
    localparam int GAP_BANK    = 4;
    localparam int VEC_BASE    = 16;
    localparam int VEC_REG     = 112;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        REG_PEND   = 2'd0,
        REG_ENABLE = 2'd1,
        REG_SENSE  = 2'd2,
        REG_INVERT = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
            q_prev <= '0;
        end else begin
            pipe[0] <= d;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
            q_prev <= pipe[STAGES-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/vic_bank.sv
module vic_bank #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] s_cur,
    input  logic [LINES-1:0] s_old,
    input  logic             wr_pend,
    input  logic             wr_enable,
    input  logic             wr_sense,
    input  logic             wr_invert,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] pend,
    output logic [LINES-1:0] enable,
    output logic [LINES-1:0] sense,
    output logic [LINES-1:0] invert
);
    logic [LINES-1:0] qual, qual_old, hit, clr, pend_nxt;

    assign qual     = s_cur ^ invert;
    assign qual_old = s_old ^ invert;
    assign hit      = qual & ~qual_old;
    assign clr      = wr_pend ? wdata : '0;

    always_comb begin
        for (int b = 0; b < LINES; b++) begin
            pend_nxt[b] = sense[b] ? ((pend[b] & ~clr[b]) | hit[b]) : qual[b];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= '0;
            enable <= '0;
            sense  <= '0;
            invert <= '0;
        end else begin
            pend <= pend_nxt;
            if (wr_enable) enable <= wdata;
            if (wr_sense)  sense  <= wdata;
            if (wr_invert) invert <= wdata;
        end
    end

    // R5: an edge line keeps its pending bit unless software clears it
    a_r5_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sense & pend & ~clr)) |=>
        ((pend & $past(sense & pend & ~clr)) == $past(sense & pend & ~clr)));

    // R7: clearing an active level line does not leave it cleared
    a_r7_level_reassert: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~sense & qual)) |=>
        ((pend & $past(clr & ~sense & qual)) == $past(clr & ~sense & qual)));
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int SRC      = 192,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 16
) (
    input  logic [SRC-1:0]   req,
    output logic             any,
    output logic [VEC_W-1:0] vec
);
    always_comb begin
        any = 1'b0;
        vec = VEC_W'(VEC_BASE);
        for (int i = 0; i < SRC; i++) begin
            if (req[i]) begin
                any = 1'b1;
                vec = VEC_W'(VEC_BASE + i);
            end
        end
    end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
    import vic_pkg::*;
#(
    parameter int NBANK  = BANKS,
    parameter int NLINE  = LINES,
    parameter int AW     = ADDR_W,
    parameter int GAP    = GAP_BANK,
    parameter int VBASE  = VEC_BASE,
    parameter int VADDR  = VEC_REG,
    parameter int NSYNC  = SYNC_STAGES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NBANK*NLINE-1:0] src_i,
    input  logic [AW-1:0]          bus_addr,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [NLINE-1:0]       bus_wdata,
    output logic [NLINE-1:0]       bus_rdata,
    output logic                   irq_o
);
    localparam int NSRC   = NBANK * NLINE;
    localparam int HOLE_LO = 4 * GAP;
    localparam int HOLE_HI = HOLE_LO + 4;

    logic [NSRC-1:0]  s_cur, s_old, pend_flat, en_flat;
    logic [NLINE-1:0] pend_a [NBANK];
    logic [NLINE-1:0] en_a   [NBANK];
    logic [NLINE-1:0] sense_a[NBANK];
    logic [NLINE-1:0] inv_a  [NBANK];

    logic             dec_hit, is_hole;
    int               dec_bank;
    reg_sel_e         dec_sel;
    logic             any_req;
    logic [NLINE-1:0] vec_next, vec_q;

    vic_sync #(.W(NSRC), .STAGES(NSYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(src_i), .q(s_cur), .q_prev(s_old)
    );

    always_comb begin
        int a;
        a        = int'(bus_addr);
        dec_sel  = reg_sel_e'(bus_addr[1:0]);
        is_hole  = (a >= HOLE_LO) && (a < HOLE_HI);
        if (a < HOLE_LO) begin
            dec_bank = a / 4;
            dec_hit  = 1'b1;
        end else if (is_hole) begin
            dec_bank = 0;
            dec_hit  = 1'b0;
        end else begin
            dec_bank = (a - 4) / 4;
            dec_hit  = dec_bank < NBANK;
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic sel_me;
        assign sel_me = bus_wr && dec_hit && (dec_bank == g);

        vic_bank #(.LINES(NLINE)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .s_cur    (s_cur[g*NLINE +: NLINE]),
            .s_old    (s_old[g*NLINE +: NLINE]),
            .wr_pend  (sel_me && dec_sel == REG_PEND),
            .wr_enable(sel_me && dec_sel == REG_ENABLE),
            .wr_sense (sel_me && dec_sel == REG_SENSE),
            .wr_invert(sel_me && dec_sel == REG_INVERT),
            .wdata    (bus_wdata),
            .pend     (pend_a[g]),
            .enable   (en_a[g]),
            .sense    (sense_a[g]),
            .invert   (inv_a[g])
        );

        assign pend_flat[g*NLINE +: NLINE] = pend_a[g];
        assign en_flat[g*NLINE +: NLINE]   = en_a[g];
    end

    vic_prio #(.SRC(NSRC), .VEC_W(NLINE), .VEC_BASE(VBASE)) u_prio (
        .req(pend_flat & en_flat), .any(any_req), .vec(vec_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= NLINE'(VBASE);
            irq_o <= 1'b0;
        end else begin
            vec_q <= vec_next;
            irq_o <= any_req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (int'(bus_addr) == VADDR) begin
                bus_rdata <= vec_q;
            end else if (dec_hit) begin
                unique case (dec_sel)
                    REG_PEND:   bus_rdata <= pend_a[dec_bank];
                    REG_ENABLE: bus_rdata <= en_a[dec_bank];
                    REG_SENSE:  bus_rdata <= sense_a[dec_bank];
                    REG_INVERT: bus_rdata <= inv_a[dec_bank];
                endcase
            end else begin
                bus_rdata <= '0;
            end
        end
    end

    // R1: with every line masked the request line drops
    a_r1_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_flat == '0) |=> !irq_o);

    // R2: the hole reads as zero
    a_r2_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_hole) |=> (bus_rdata == '0));

    // R10: a quiet request line always comes with the bare offset
    a_r10_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vec_q == NLINE'(VBASE)));

    // R8: the vector never points past the last line
    a_r8_vec_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(vec_q) >= VBASE) && (int'(vec_q) < VBASE + NSRC));
endmodule

// File: tb/test_vec_intc.sv
module test_vec_intc;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [191:0] src = '0;
    logic [6:0]   addr = '0;
    logic         wr = 1'b0, rd = 1'b0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic         irq;
    int           total = 0, bad = 0;
    logic         done = 1'b0;

    always #4 clk = ~clk;

    vec_intc i_vec_intc (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr),
        .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_o(irq)
    );

    function automatic logic [6:0] base_of(int g);
        return (g < 4) ? 7'(4 * g) : 7'(4 * g + 4);
    endfunction

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(logic [6:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(logic [6:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; v = rdata;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd_reg(base_of(0) + 1, v); chk("R1", "enable bank0", v, 8'h00);
        rd_reg(base_of(23) + 1, v); chk("R1", "enable bank23", v, 8'h00);
        rd_reg(base_of(9) + 2, v);  chk("R1", "sense bank9", v, 8'h00);
        rd_reg(base_of(0), v);      chk("R1", "pending bank0", v, 8'h00);
        rd_reg(7'h70, v);           chk("R1", "vector", v, 8'h10);
        chk("R1", "irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_map();
        logic [7:0] v;
        wr_reg(7'd13, 8'hA5);
        wr_reg(7'd21, 8'h3C);
        wr_reg(7'd99, 8'h81);
        wr_reg(7'd17, 8'hFF);
        rd_reg(7'd13, v); chk("R2", "bank3 enable", v, 8'hA5);
        rd_reg(7'd21, v); chk("R2", "bank4 enable", v, 8'h3C);
        rd_reg(7'd99, v); chk("R2", "bank23 invert", v, 8'h81);
        rd_reg(7'd17, v); chk("R2", "hole read", v, 8'h00);
        rd_reg(7'd20, v); chk("R2", "bank4 pending after hole write", v, 8'h00);
        rd_reg(7'd14, v); chk("R2", "bank3 sense after hole write", v, 8'h00);
        wr_reg(7'd13, 8'h00);
        wr_reg(7'd21, 8'h00);
        wr_reg(7'd99, 8'h00);
        settle();
    endtask

    task automatic t_level_high();
        logic [7:0] v;
        wr_reg(base_of(1) + 1, 8'h04);
        src[10] = 1'b1; settle();
        rd_reg(base_of(1), v); chk("R3", "level high pending", v, 8'h04);
        chk("R9", "irq with enabled level", {7'd0, irq}, 8'h01);
        rd_reg(7'h70, v); chk("R8", "vector line10", v, 8'd26);
        wr_reg(base_of(1), 8'h04); settle();
        rd_reg(base_of(1), v); chk("R7", "level clear while active", v, 8'h04);
        src[10] = 1'b0; settle();
        rd_reg(base_of(1), v); chk("R3", "level low clears", v, 8'h00);
        chk("R10", "irq idle", {7'd0, irq}, 8'h00);
        rd_reg(7'h70, v); chk("R10", "idle vector", v, 8'h10);
        wr_reg(base_of(1) + 1, 8'h00);
    endtask

    task automatic t_level_low();
        logic [7:0] v;
        wr_reg(base_of(5) + 3, 8'h01); settle();
        rd_reg(base_of(5), v); chk("R4", "active low, input low", v, 8'h01);
        src[40] = 1'b1; settle();
        rd_reg(base_of(5), v); chk("R4", "active low, input high", v, 8'h00);
    endtask

    task automatic t_edge_rise();
        logic [7:0] v;
        wr_reg(base_of(12) + 2, 8'h10);
        src[100] = 1'b1; settle();
        src[100] = 1'b0; settle();
        rd_reg(base_of(12), v); chk("R5", "rising edge held", v, 8'h10);
        wr_reg(base_of(12), 8'h00); settle();
        rd_reg(base_of(12), v); chk("R5", "write 0 keeps", v, 8'h10);
        wr_reg(base_of(12), 8'h10); settle();
        rd_reg(base_of(12), v); chk("R5", "write 1 clears", v, 8'h00);
    endtask

    task automatic t_edge_fall();
        logic [7:0] v;
        wr_reg(base_of(23) + 2, 8'h80);
        wr_reg(base_of(23) + 3, 8'h80); settle();
        wr_reg(base_of(23), 8'hFF);
        src[191] = 1'b1; settle();
        rd_reg(base_of(23), v); chk("R6", "rise ignored", v, 8'h00);
        src[191] = 1'b0; settle();
        rd_reg(base_of(23), v); chk("R6", "fall captured", v, 8'h80);
        wr_reg(base_of(23), 8'h80); settle();
    endtask

    task automatic t_priority();
        logic [7:0] v, w;
        wr_reg(base_of(1) + 1, 8'h04);
        wr_reg(base_of(12) + 1, 8'h30);
        wr_reg(base_of(12) + 2, 8'h30);
        wr_reg(base_of(23) + 1, 8'h80);
        src[10] = 1'b1; src[100] = 1'b1; src[191] = 1'b1; settle();
        src[100] = 1'b0; src[191] = 1'b0; settle();
        rd_reg(7'h70, v); chk("R8", "top bank wins", v, 8'd207);
        rd_reg(7'h70, w); chk("R8", "repeat read stable", w, v);
        wr_reg(base_of(23), 8'h80); settle();
        rd_reg(7'h70, v); chk("R8", "next bank", v, 8'd116);
        src[101] = 1'b1; settle();
        rd_reg(7'h70, v); chk("R8", "msb within bank", v, 8'd117);
        wr_reg(base_of(12), 8'h30); settle();
        rd_reg(7'h70, v); chk("R8", "lowest remaining", v, 8'd26);
        src[10] = 1'b0; src[101] = 1'b0;
        src[3] = 1'b1; settle();
        chk("R9", "masked line keeps irq low", {7'd0, irq}, 8'h00);
        rd_reg(base_of(0), v); chk("R9", "masked line visible", v, 8'h08);
        rd_reg(7'h70, v); chk("R10", "masked vector idle", v, 8'h10);
        src[3] = 1'b0;
        wr_reg(base_of(0) + 1, 8'h01);
        src[0] = 1'b1; settle();
        chk("R10", "line0 irq high", {7'd0, irq}, 8'h01);
        rd_reg(7'h70, v); chk("R10", "line0 vector", v, 8'h10);
        src[0] = 1'b0; settle();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_level_high();
        t_level_low();
        t_edge_rise();
        t_edge_fall();
        t_priority();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule